// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer whose write and read sides run on independent clocks. One storage core of 2**ADDR_W words serves two operating modes, and the mode is latched from a select pin while the master reset is held. After reset the mode cannot change.

In standard mode the two status pins act as an active-low full flag and an active-low empty flag. A read request moves the head word from storage into a registered output. In first-word-fall-through mode the same two pins act as input-ready and output-ready, both active-low. The head word is loaded into the output register without any request. Because that register counts as one more slot, the buffer holds D+1 words, where D = 2**ADDR_W. Write and read pointers cross between the clocks as Gray code through two-flop synchronisers, so flags that clear do so late.

The write side runs a two-state machine. WR_OPEN goes to WR_BLOCKED on the write that fills the last storage slot. WR_BLOCKED goes back to WR_OPEN once the synchronised read pointer shows free space. The read side keeps a registered storage-empty bit and an output-stage machine that is used only in first-word-fall-through mode. OUT_VOID goes to OUT_LIVE on the cycle that storage is non-empty, and the head word is loaded on that cycle. OUT_LIVE goes back to OUT_VOID on a true read when storage has nothing left to load. OUT_LIVE stays in OUT_LIVE when there is no read, and also on a true read that reloads the next word. In standard mode the output stage stays in OUT_VOID.

Top module: `dual_mode_fifo`

## Requirements
- R1: The mode pin (0 = standard, 1 = first-word-fall-through) is captured while mrst_n is low. Straight after reset, standard mode shows full_ir=1 and empty_or=0, and first-word-fall-through mode shows full_ir=0 and empty_or=1.
- R2: In standard mode, with no reads since reset, full_ir is 1 after D-1 writes and is 0 straight after the D-th write.
- R3: A write offered while the FIFO reports full (standard full_ir=0, fall-through full_ir=1) is discarded. It never appears at the read side and does not move the write pointer.
- R4: In standard mode, empty_or=1 means data is held. A read (rd_en_n=0 on a rd_clk rising edge) while empty_or=1 loads the oldest word into rd_data at that edge. Words leave in write order.
- R5: In standard mode, empty_or returns to 0 after the last word is read. A read while empty_or=0 leaves rd_data and the read pointer unchanged.
- R6: In fall-through mode, the first word written into an empty FIFO appears on rd_data in the same rd_clk cycle that empty_or falls to 0, with no read request.
- R7: In fall-through mode, with no reads, once the first word is on the outputs full_ir stays 0 through D writes in total and becomes 1 after D+1 writes.
- R8: In fall-through mode, empty_or rises only after a true read (rd_en_n=0 at a rd_clk rising edge). Without a read, rd_data and empty_or=0 hold. After the last word is read, rd_data keeps that word, and reads while empty_or=1 change nothing.
- R9: After a read frees a slot in a full standard-mode FIFO, full_ir returns to 1 within 6 wr_clk cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| mode_fwft | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Write data |
| rd_en_n | input | 1 | Read request, active low |
| rd_data | output | DATA_W | Registered read data |
| full_ir | output | 1 | Full flag (standard) or input-ready (fall-through), active low |
| empty_or | output | 1 | Empty flag (standard) or output-ready (fall-through), active low |

## Verification
The bench builds the block with DATA_W=8 and ADDR_W=3, so D is eight words. At that depth both the standard-mode full boundary and the fall-through boundary of D+1 words are reached in a few dozen cycles, and the bench can drive writes past them to show that the extra words are dropped. The two clocks run at unrelated periods, so the Gray-coded pointer crossings and the late clearing of flags are exercised in both directions, each mode following its own reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    // write-side occupancy state
    typedef enum logic {
        WR_OPEN    = 1'b0,
        WR_BLOCKED = 1'b1
    } wr_state_e;

    // fall-through output stage state
    typedef enum logic {
        OUT_VOID = 1'b0,
        OUT_LIVE = 1'b1
    } out_state_e;
endpackage

// File: rtl/dmf_store.sv
module dmf_store #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_sync.sv
module dmf_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= '0;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side
    import dmf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              mrst_n,
    input  logic              mode_pin,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rq_gray,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W:0]   wptr,
    output logic              full_ir,
    output logic              fwft_q
);
    localparam int PW = ADDR_W + 1;

    wr_state_e        st_q, st_d;
    logic [PW-1:0]    wbin_q, wbin_d, wgray_d, full_pat;

    // a full buffer has a write pointer whose top two Gray bits differ from the read pointer
    always_comb begin
        full_pat = {~rq_gray[PW-1:PW-2], rq_gray[PW-3:0]};
    end

    always_comb begin
        we = 1'b0;
        unique case (st_q)
            WR_OPEN:    we = !wr_en_n;
            WR_BLOCKED: we = 1'b0;
        endcase
        wbin_d  = wbin_q + PW'(we);
        wgray_d = wbin_d ^ (wbin_d >> 1);
        st_d    = (wgray_d == full_pat) ? WR_BLOCKED : WR_OPEN;
    end

    always_ff @(posedge wr_clk or negedge mrst_n) begin
        if (!mrst_n) begin
            st_q   <= WR_OPEN;
            wbin_q <= '0;
            wgray  <= '0;
            fwft_q <= mode_pin;
        end else begin
            st_q   <= st_d;
            wbin_q <= wbin_d;
            wgray  <= wgray_d;
        end
    end

    always_comb begin
        full_ir = fwft_q ? (st_q == WR_BLOCKED) : (st_q != WR_BLOCKED);
        waddr   = wbin_q[ADDR_W-1:0];
        wptr    = wbin_q;
    end
endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
    import dmf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              mode_pin,
    input  logic              rd_en_n,
    input  logic [ADDR_W:0]   wq_gray,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W:0]   rptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_or,
    output logic              fwft_q
);
    localparam int PW = ADDR_W + 1;

    out_state_e       ost_q, ost_d;
    logic             core_empty_q, core_empty_d;
    logic             pop, true_rd;
    logic [PW-1:0]    rbin_q, rbin_d, rgray_d;

    // next output-stage state and storage pop
    always_comb begin
        true_rd = !rd_en_n;
        pop     = 1'b0;
        ost_d   = ost_q;
        if (!fwft_q) begin
            pop   = true_rd && !core_empty_q;
            ost_d = OUT_VOID;
        end else begin
            unique case (ost_q)
                OUT_VOID: begin
                    pop   = !core_empty_q;
                    ost_d = pop ? OUT_LIVE : OUT_VOID;
                end
                OUT_LIVE: begin
                    pop   = true_rd && !core_empty_q;
                    ost_d = (true_rd && !pop) ? OUT_VOID : OUT_LIVE;
                end
            endcase
        end
        rbin_d       = rbin_q + PW'(pop);
        rgray_d      = rbin_d ^ (rbin_d >> 1);
        core_empty_d = (rgray_d == wq_gray);
    end

    always_ff @(posedge rd_clk or negedge mrst_n) begin
        if (!mrst_n) begin
            ost_q        <= OUT_VOID;
            core_empty_q <= 1'b1;
            rbin_q       <= '0;
            rgray        <= '0;
            rd_data      <= '0;
            fwft_q       <= mode_pin;
        end else begin
            ost_q        <= ost_d;
            core_empty_q <= core_empty_d;
            rbin_q       <= rbin_d;
            rgray        <= rgray_d;
            if (pop) begin
                rd_data <= mem_rdata;
            end
        end
    end

    always_comb begin
        empty_or = fwft_q ? (ost_q == OUT_VOID) : !core_empty_q;
        raddr    = rbin_q[ADDR_W-1:0];
        rptr     = rbin_q;
    end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              mode_fwft,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              full_ir,
    output logic              empty_or
);
    localparam int PW = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic [PW-1:0]     wgray, rgray, wq_gray, rq_gray;
    logic [PW-1:0]     wr_ptr_bin, rd_ptr_bin;
    logic              wr_mode_fwft, rd_mode_fwft;

    dmf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    dmf_sync #(.WIDTH(PW), .STAGES(2)) u_rq_sync (
        .clk   (wr_clk),
        .rst_n (mrst_n),
        .d     (rgray),
        .q     (rq_gray)
    );

    dmf_sync #(.WIDTH(PW), .STAGES(2)) u_wq_sync (
        .clk   (rd_clk),
        .rst_n (mrst_n),
        .d     (wgray),
        .q     (wq_gray)
    );

    dmf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk   (wr_clk),
        .mrst_n   (mrst_n),
        .mode_pin (mode_fwft),
        .wr_en_n  (wr_en_n),
        .rq_gray  (rq_gray),
        .we       (we),
        .waddr    (waddr),
        .wgray    (wgray),
        .wptr     (wr_ptr_bin),
        .full_ir  (full_ir),
        .fwft_q   (wr_mode_fwft)
    );

    dmf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk    (rd_clk),
        .mrst_n    (mrst_n),
        .mode_pin  (mode_fwft),
        .rd_en_n   (rd_en_n),
        .wq_gray   (wq_gray),
        .mem_rdata (mem_rdata),
        .raddr     (raddr),
        .rgray     (rgray),
        .rptr      (rd_ptr_bin),
        .rd_data   (rd_data),
        .empty_or  (empty_or),
        .fwft_q    (rd_mode_fwft)
    );
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mrst_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              full_ir,
    input logic              empty_or,
    input logic [ADDR_W:0]   wr_ptr,
    input logic [ADDR_W:0]   rd_ptr,
    input logic              wfwft,
    input logic              rfwft
);
    logic wfull, rnone;
    assign wfull = (wfwft == full_ir);
    assign rnone = (rfwft == empty_or);

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (wfull && !wr_en_n) |=> $stable(wr_ptr)); // R3

    AST_FULL_BY_WRITE: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $rose(wfull) |-> $past(!wr_en_n)); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (!rfwft && rnone && !rd_en_n) |=> ($stable(rd_ptr) && $stable(rd_data))); // R5

    AST_DRAIN_BY_READ: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        $rose(rnone) |-> $past(!rd_en_n)); // R8

    AST_HEAD_HELD: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        (rfwft && !rnone && rd_en_n) |=> (!rnone && $stable(rd_data))); // R8
endmodule

bind dual_mode_fifo dmf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .mrst_n   (mrst_n),
    .wr_en_n  (wr_en_n),
    .rd_en_n  (rd_en_n),
    .rd_data  (rd_data),
    .full_ir  (full_ir),
    .empty_or (empty_or),
    .wr_ptr   (wr_ptr_bin),
    .rd_ptr   (rd_ptr_bin),
    .wfwft    (wr_mode_fwft),
    .rfwft    (rd_mode_fwft)
);

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst_n = 1'b0;
    logic          mode_fwft = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          full_ir, empty_or;

    int vectors = 0;
    int miscompares = 0;
    logic [DW-1:0] sb [$];
    bit pending = 1'b0;

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    dual_mode_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .wr_clk    (wr_clk),
        .rd_clk    (rd_clk),
        .mrst_n    (mrst_n),
        .mode_fwft (mode_fwft),
        .wr_en_n   (wr_en_n),
        .wr_data   (wr_data),
        .rd_en_n   (rd_en_n),
        .rd_data   (rd_data),
        .full_ir   (full_ir),
        .empty_or  (empty_or)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: pops the scoreboard whenever a word leaves the read side
    always @(negedge rd_clk) begin
        if (!mrst_n) begin
            pending = 1'b0;
        end else if (mode_fwft) begin
            if (!rd_en_n && !empty_or) begin
                if (sb.size() == 0) chk(1'b0, "R8 unexpected word", 32'(rd_data), 32'hx);
                else begin
                    logic [DW-1:0] e;
                    e = sb.pop_front();
                    chk(rd_data == e, "R8 order", 32'(rd_data), 32'(e));
                end
            end
        end else begin
            if (pending) begin
                if (sb.size() == 0) chk(1'b0, "R4 unexpected word", 32'(rd_data), 32'hx);
                else begin
                    logic [DW-1:0] e;
                    e = sb.pop_front();
                    chk(rd_data == e, "R4 order", 32'(rd_data), 32'(e));
                end
            end
            pending = !rd_en_n && empty_or;
        end
    end

    task automatic do_reset(input logic m);
        mode_fwft = m;
        wr_en_n   = 1'b1;
        rd_en_n   = 1'b1;
        mrst_n    = 1'b0;
        repeat (4) @(posedge wr_clk);
        #3 mrst_n = 1'b1;
        sb.delete();
        repeat (3) @(posedge rd_clk);
    endtask

    task automatic push_wr(input logic [DW-1:0] d, input bit take);
        @(posedge wr_clk); #2;
        wr_en_n = 1'b0;
        wr_data = d;
        @(posedge wr_clk); #2;
        wr_en_n = 1'b1;
        if (take) sb.push_back(d);
    endtask

    // one read, issued once the flag shows a word is available
    task automatic pull_rd();
        forever begin
            @(posedge rd_clk); #2;
            if (mode_fwft ? !empty_or : empty_or) break;
        end
        rd_en_n = 1'b0;
        @(posedge rd_clk); #2;
        rd_en_n = 1'b1;
    endtask

    task automatic run_all();
        int waited;
        // ---------------- standard mode ----------------
        do_reset(1'b0);
        @(negedge wr_clk);
        chk(full_ir == 1'b1, "R1 std full_ir", 32'(full_ir), 32'd1);
        chk(empty_or == 1'b0, "R1 std empty_or", 32'(empty_or), 32'd0);

        @(posedge rd_clk); #2 rd_en_n = 1'b0;
        repeat (3) @(posedge rd_clk);
        #2 rd_en_n = 1'b1;
        @(negedge rd_clk);
        chk(rd_data == '0, "R5 read while empty", 32'(rd_data), 32'd0);

        for (int i = 0; i < D; i++) begin
            push_wr(DW'(8'h10 + i), 1'b1);
            @(negedge wr_clk);
            if (i == D - 2) chk(full_ir == 1'b1, "R2 not full at D-1", 32'(full_ir), 32'd1);
            if (i == D - 1) chk(full_ir == 1'b0, "R2 full at D", 32'(full_ir), 32'd0);
        end
        push_wr(8'hEE, 1'b0);   // R3 dropped
        push_wr(8'hEF, 1'b0);   // R3 dropped
        @(negedge wr_clk);
        chk(full_ir == 1'b0, "R3 still full", 32'(full_ir), 32'd0);

        for (int i = 0; i < D; i++) pull_rd();
        repeat (6) @(negedge rd_clk);
        chk(empty_or == 1'b0, "R5 empty after drain", 32'(empty_or), 32'd0);
        chk(rd_data == DW'(8'h10 + D - 1), "R5 last word held", 32'(rd_data), 32'(8'h10 + D - 1));
        chk(sb.size() == 0, "R3 no extra words", 32'(sb.size()), 32'd0);
        @(posedge rd_clk); #2 rd_en_n = 1'b0;
        repeat (2) @(posedge rd_clk);
        #2 rd_en_n = 1'b1;
        @(negedge rd_clk);
        chk(rd_data == DW'(8'h10 + D - 1), "R5 read while empty held", 32'(rd_data), 32'(8'h10 + D - 1));

        // R9: free one slot in a full buffer
        for (int i = 0; i < D; i++) push_wr(DW'(8'h60 + i), 1'b1);
        @(negedge wr_clk);
        chk(full_ir == 1'b0, "R9 full before read", 32'(full_ir), 32'd0);
        pull_rd();
        waited = 0;
        while (full_ir == 1'b0 && waited < 20) begin
            @(negedge wr_clk);
            waited++;
        end
        chk(waited <= 6, "R9 full clears", 32'(waited), 32'd6);
        for (int i = 1; i < D; i++) pull_rd();
        repeat (4) @(negedge rd_clk);
        chk(sb.size() == 0, "R4 all words read", 32'(sb.size()), 32'd0);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        @(negedge wr_clk);
        chk(full_ir == 1'b0, "R1 fwft full_ir", 32'(full_ir), 32'd0);
        chk(empty_or == 1'b1, "R1 fwft empty_or", 32'(empty_or), 32'd1);

        push_wr(8'h40, 1'b1);
        waited = 0;
        do begin
            @(negedge rd_clk);
            waited++;
        end while (empty_or == 1'b1 && waited < 20);
        chk(empty_or == 1'b0, "R6 output ready", 32'(empty_or), 32'd0);
        chk(rd_data == 8'h40, "R6 head word shown", 32'(rd_data), 32'h40);
        repeat (5) @(negedge rd_clk);
        chk(empty_or == 1'b0 && rd_data == 8'h40, "R8 held without read", 32'(rd_data), 32'h40);

        for (int i = 1; i <= D; i++) begin
            push_wr(DW'(8'h40 + i), 1'b1);
            @(negedge wr_clk);
            if (i == D - 1) chk(full_ir == 1'b0, "R7 ready at D", 32'(full_ir), 32'd0);
            if (i == D)     chk(full_ir == 1'b1, "R7 not ready at D+1", 32'(full_ir), 32'd1);
        end
        push_wr(8'hEE, 1'b0);   // R3 dropped in fall-through mode
        @(negedge wr_clk);
        chk(full_ir == 1'b1, "R3 fwft still not ready", 32'(full_ir), 32'd1);

        for (int i = 0; i <= D; i++) pull_rd();
        repeat (4) @(negedge rd_clk);
        chk(empty_or == 1'b1, "R8 not ready after drain", 32'(empty_or), 32'd1);
        chk(rd_data == DW'(8'h40 + D), "R8 last word stays", 32'(rd_data), 32'(8'h40 + D));
        chk(sb.size() == 0, "R3 fwft no extra words", 32'(sb.size()), 32'd0);
        @(posedge rd_clk); #2 rd_en_n = 1'b0;
        repeat (3) @(posedge rd_clk);
        #2 rd_en_n = 1'b1;
        @(negedge rd_clk);
        chk(empty_or == 1'b1 && rd_data == DW'(8'h40 + D), "R8 read while not ready",
            32'(rd_data), 32'(8'h40 + D));
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge wr_clk);
                chk(1'b0, "watchdog", 32'd0, 32'd1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule